// File: doc/BRIEF.md
# Dual Calendar Alarm Comparator

This block holds two calendar alarms, each a set of six BCD fields (seconds, minutes, hours, day, month, year), and compares both against the running calendar every time the calendar advances. A timekeeping counter outside the block supplies the current fields and a one-cycle update strobe. Only an exact match on all six fields counts, because no field can be masked. An alarm event sets a sticky status flag. Software clears that flag by writing a one to it.

The first alarm can drive the interrupt line, and it can also drive a wake line for a power manager. The second alarm can drive the interrupt line too. When power control is armed, the second alarm also drops an external power-enable output to its off level. That output stays off until software disarms power control or the block is reset. Software reaches every register through a byte-wide write port and a combinational read port.

Top module: `rtc_alarm_pair`

## Requirements
- R1: Alarm 1 field i sits at byte address 0x20+4*i and alarm 2 field i at 0x80+4*i, with i = 0..5 meaning seconds, minutes, hours, day, month, year. A write stores the byte, and the same address reads it back. All alarm fields reset to 0x00.
- R2: An alarm event happens only in a cycle where `tick_i` is high and all six stored fields equal the matching bytes of `now_i` (byte i of `now_i` is field i). A mismatch in any single field gives no event.
- R3: Status register 0x44 holds the alarm 1 flag in bit 6 and the alarm 2 flag in bit 7. An event sets its flag on the clock edge that samples the strobe. Both flags reset to 0.
- R4: Writing 0x44 clears each flag whose data bit is 1 and leaves flags written with 0 unchanged. If a clear and a new event arrive on the same edge, the event wins and the flag stays set.
- R5: Register 0x48 bit 3 enables alarm 1 and bit 4 enables alarm 2 onto `irq_o`. `irq_o` is high whenever an enabled flag is set.
- R6: Register 0x7C bit 1 enables alarm 1 onto `wake_o`. `wake_o` is high whenever that enable and the alarm 1 flag are both set.
- R7: Power control is bit 0 of byte 0x9A (bit 16 of the word at 0x98). `pwr_en_o` is 1 out of reset. An alarm 2 event while power control is armed drives it to 0 on that edge. An alarm 2 event while power control is disarmed leaves it at 1.
- R8: Once `pwr_en_o` is 0, it returns to 1 only through reset or through a write of 0 to the power-control bit. Clearing the alarm 2 flag and later strobes do not restore it.
- R9: The comparison uses the alarm fields held before the sampling edge. A field written in the strobe cycle first counts at the following strobe. A field written in any earlier cycle counts at the next strobe.
- R10: A calendar that equals an alarm while `tick_i` is low produces no event, however long the equality lasts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle strobe, high when `now_i` holds a freshly advanced time |
| now_i | input | 48 | Current calendar, six BCD bytes, seconds in the low byte |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Register byte address for read and write |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Alarm interrupt, level |
| wake_o | output | 1 | Alarm 1 wake request, level |
| pwr_en_o | output | 1 | External power enable, 1 = on |

## Verification
On every cycle, the assertions inside the RTL check four things. Each stored field takes exactly the byte written to it. A status flag only rises after a strobe that carried a full match. A clear without a competing event leaves the flag low. The power-enable output only falls after an armed alarm 2 event, and it only rises once power control is disarmed. Other behaviours need the bench's scenarios to show them: a single mismatched field blocks the event, an alarm write in the strobe cycle takes effect one strobe late, a clear and an event on the same edge leave the flag set, and clearing the flag leaves power off. The bench runs those scenarios while a behavioural model tracks `irq_o`, `wake_o` and `pwr_en_o` on every clock.

// File: rtl/rap_pkg.sv
package rap_pkg;
   localparam int BYTE_W      = 8;
   localparam int ALARM_CNT   = 2;
   localparam int STAT_OFS    = 'h44;
   localparam int IEN_OFS     = 'h48;
   localparam int WAKE_OFS    = 'h7C;
   localparam int PWR_OFS     = 'h9A;
   localparam int ST_BIT_A1   = 6;
   localparam int ST_BIT_A2   = 7;
   localparam int IE_BIT_A1   = 3;
   localparam int IE_BIT_A2   = 4;
   localparam int WAKE_BIT    = 1;
   localparam int PWR_BIT     = 0;
endpackage

// File: rtl/rap_alarm_slot.sv
module rap_alarm_slot #(
   parameter int FIELD_W  = 8,
   parameter int N_FIELDS = 6,
   parameter int ADDR_W   = 8,
   parameter int BASE     = 'h20,
   parameter int STRIDE   = 4
) (
   input  logic                         clk_i,
   input  logic                         rst_ni,
   input  logic                         wr_en_i,
   input  logic [ADDR_W-1:0]            addr_i,
   input  logic [FIELD_W-1:0]           wdata_i,
   input  logic [N_FIELDS*FIELD_W-1:0]  now_i,
   output logic [FIELD_W-1:0]           rd_o,
   output logic                         match_o
);
   localparam int LAST_ADDR = BASE + (N_FIELDS-1)*STRIDE;

   if (LAST_ADDR >= (1 << ADDR_W)) begin : g_bad_range
      $error("alarm slot fields exceed address space");
   end

   logic [N_FIELDS-1:0][FIELD_W-1:0] fld_q;
   logic [N_FIELDS-1:0]              sel;
   logic [N_FIELDS-1:0]              eq;

   for (genvar f = 0; f < N_FIELDS; f++) begin : g_field
      localparam logic [ADDR_W-1:0] FA = ADDR_W'(BASE + f*STRIDE);
      assign sel[f] = (addr_i == FA);
      assign eq[f]  = (fld_q[f] == now_i[f*FIELD_W +: FIELD_W]);

      // R1: a written field holds exactly the written byte
      a_r1_field_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
         $past(wr_en_i && sel[f]) |-> fld_q[f] == $past(wdata_i));
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         fld_q <= '0;
      end else begin
         for (int f = 0; f < N_FIELDS; f++) begin
            if (wr_en_i && sel[f]) fld_q[f] <= wdata_i;
         end
      end
   end

   always_comb begin
      rd_o = '0;
      for (int f = 0; f < N_FIELDS; f++) begin
         if (sel[f]) rd_o = rd_o | fld_q[f];
      end
   end

   assign match_o = &eq;
endmodule

// File: rtl/rap_event_ctrl.sv
module rap_event_ctrl
   import rap_pkg::*;
#(
   parameter int ADDR_W = 8
) (
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  logic                  tick_i,
   input  logic [ALARM_CNT-1:0]  match_i,
   input  logic                  wr_en_i,
   input  logic [ADDR_W-1:0]     addr_i,
   input  logic [BYTE_W-1:0]     wdata_i,
   output logic [ALARM_CNT-1:0]  status_o,
   output logic [ALARM_CNT-1:0]  ien_o,
   output logic                  wake_en_o,
   output logic                  pwr_off_o,
   output logic [BYTE_W-1:0]     rd_o
);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_OFS);
   localparam logic [ADDR_W-1:0] A_IEN  = ADDR_W'(IEN_OFS);
   localparam logic [ADDR_W-1:0] A_WAKE = ADDR_W'(WAKE_OFS);
   localparam logic [ADDR_W-1:0] A_PWR  = ADDR_W'(PWR_OFS);
   localparam int ST_BITS [ALARM_CNT] = '{ST_BIT_A1, ST_BIT_A2};
   localparam int IE_BITS [ALARM_CNT] = '{IE_BIT_A1, IE_BIT_A2};

   logic [ALARM_CNT-1:0] ev, clr, st_q, ie_q;
   logic wk_q, pc_q, off_q;
   logic wr_pwr;

   assign ev     = {ALARM_CNT{tick_i}} & match_i;
   assign wr_pwr = wr_en_i && (addr_i == A_PWR);

   for (genvar k = 0; k < ALARM_CNT; k++) begin : g_flag
      assign clr[k] = wr_en_i && (addr_i == A_STAT) && wdata_i[ST_BITS[k]];

      // R3: a flag rises only after a strobe carrying a full match
      a_r3_rise_needs_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
         $rose(st_q[k]) |-> $past(tick_i && match_i[k]));
      // R4: a clear with no competing event leaves the flag low
      a_r4_clear_wins_alone: assert property (@(posedge clk_i) disable iff (!rst_ni)
         $past(clr[k] && !ev[k]) |-> !st_q[k]);
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         st_q  <= '0;
         ie_q  <= '0;
         wk_q  <= 1'b0;
         pc_q  <= 1'b0;
         off_q <= 1'b0;
      end else begin
         st_q <= ev | (st_q & ~clr);
         if (wr_en_i && addr_i == A_IEN) begin
            for (int k = 0; k < ALARM_CNT; k++) ie_q[k] <= wdata_i[IE_BITS[k]];
         end
         if (wr_en_i && addr_i == A_WAKE) wk_q <= wdata_i[WAKE_BIT];
         if (wr_pwr) pc_q <= wdata_i[PWR_BIT];
         if (wr_pwr && !wdata_i[PWR_BIT]) off_q <= 1'b0;
         else if (ev[1] && pc_q)          off_q <= 1'b1;
      end
   end

   always_comb begin
      rd_o = '0;
      if (addr_i == A_STAT) begin
         for (int k = 0; k < ALARM_CNT; k++) rd_o[ST_BITS[k]] = st_q[k];
      end
      if (addr_i == A_IEN) begin
         for (int k = 0; k < ALARM_CNT; k++) rd_o[IE_BITS[k]] = ie_q[k];
      end
      if (addr_i == A_WAKE) rd_o[WAKE_BIT] = wk_q;
      if (addr_i == A_PWR)  rd_o[PWR_BIT]  = pc_q;
   end

   // R7: power goes off only after an armed alarm 2 event
   a_r7_off_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(off_q) |-> $past(ev[1] && pc_q));
   // R8: power returns on only once power control is disarmed
   a_r8_on_needs_disarm: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(off_q) |-> !pc_q);

   assign status_o  = st_q;
   assign ien_o     = ie_q;
   assign wake_en_o = wk_q;
   assign pwr_off_o = off_q;
endmodule

// File: rtl/rtc_alarm_pair.sv
module rtc_alarm_pair
   import rap_pkg::*;
#(
   parameter int FIELD_W   = 8,
   parameter int N_FIELDS  = 6,
   parameter int ADDR_W    = 8,
   parameter int ALM1_BASE = 'h20,
   parameter int ALM2_BASE = 'h80,
   parameter int STRIDE    = 4
) (
   input  logic                         clk_i,
   input  logic                         rst_ni,
   input  logic                         tick_i,
   input  logic [N_FIELDS*FIELD_W-1:0]  now_i,
   input  logic                         wr_en_i,
   input  logic [ADDR_W-1:0]            addr_i,
   input  logic [BYTE_W-1:0]            wdata_i,
   output logic [BYTE_W-1:0]            rdata_o,
   output logic                         irq_o,
   output logic                         wake_o,
   output logic                         pwr_en_o
);
   localparam int BASES [ALARM_CNT] = '{ALM1_BASE, ALM2_BASE};

   if (FIELD_W != BYTE_W) begin : g_bad_width
      $error("alarm fields must be one register byte wide");
   end
   if (ADDR_W < 8) begin : g_bad_addr
      $error("address too narrow for the control registers");
   end

   logic [ALARM_CNT-1:0]              match, status, ien;
   logic [ALARM_CNT-1:0][BYTE_W-1:0]  slot_rd;
   logic [BYTE_W-1:0]                 ctl_rd;
   logic                              wake_en, pwr_off;

   for (genvar k = 0; k < ALARM_CNT; k++) begin : g_slot
      rap_alarm_slot #(
         .FIELD_W (FIELD_W),
         .N_FIELDS(N_FIELDS),
         .ADDR_W  (ADDR_W),
         .BASE    (BASES[k]),
         .STRIDE  (STRIDE)
      ) slot_i (
         .clk_i  (clk_i),
         .rst_ni (rst_ni),
         .wr_en_i(wr_en_i),
         .addr_i (addr_i),
         .wdata_i(wdata_i),
         .now_i  (now_i),
         .rd_o   (slot_rd[k]),
         .match_o(match[k])
      );
   end

   rap_event_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .tick_i   (tick_i),
      .match_i  (match),
      .wr_en_i  (wr_en_i),
      .addr_i   (addr_i),
      .wdata_i  (wdata_i),
      .status_o (status),
      .ien_o    (ien),
      .wake_en_o(wake_en),
      .pwr_off_o(pwr_off),
      .rd_o     (ctl_rd)
   );

   assign rdata_o  = slot_rd[0] | slot_rd[1] | ctl_rd;
   assign irq_o    = |(status & ien);
   assign wake_o   = status[0] & wake_en;
   assign pwr_en_o = ~pwr_off;
endmodule

// File: tb/rtc_alarm_pair_tb_top.sv
`timescale 1ns/1ps
module rtc_alarm_pair_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0;
   logic [47:0] now = '0;
   logic        wr = 1'b0;
   logic [7:0]  addr = '0;
   logic [7:0]  wdata = '0;
   logic [7:0]  rdata;
   logic        irq, wake, pwr_en;

   int total = 0;
   int bad = 0;
   bit done = 0;

   always #10 clk = ~clk;

   rtc_alarm_pair dut_i (
      .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .now_i(now),
      .wr_en_i(wr), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
      .irq_o(irq), .wake_o(wake), .pwr_en_o(pwr_en)
   );

   // behavioural reference model
   logic [7:0] m_alm [2][6];
   bit m_st [2];
   bit m_ie [2];
   bit m_wk, m_pc, m_off;
   int bases [2] = '{'h20, 'h80};

   always @(posedge clk) begin : model
      bit ev [2];
      bit pc_old;
      bit clr;
      bit e_irq, e_wake, e_pwr;
      if (!rst_n) begin
         for (int k = 0; k < 2; k++) begin
            for (int f = 0; f < 6; f++) m_alm[k][f] = 8'h00;
            m_st[k] = 0; m_ie[k] = 0;
         end
         m_wk = 0; m_pc = 0; m_off = 0;
      end else begin
         for (int k = 0; k < 2; k++) begin
            ev[k] = tick;
            for (int f = 0; f < 6; f++)
               if (m_alm[k][f] != now[8*f +: 8]) ev[k] = 0;
         end
         pc_old = m_pc;
         if (wr) begin
            for (int k = 0; k < 2; k++)
               for (int f = 0; f < 6; f++)
                  if (addr == 8'(bases[k] + 4*f)) m_alm[k][f] = wdata;
         end
         for (int k = 0; k < 2; k++) begin
            clr = wr && addr == 8'h44 && wdata[6+k];
            m_st[k] = ev[k] | (m_st[k] & !clr);
         end
         if (wr && addr == 8'h48) begin m_ie[0] = wdata[3]; m_ie[1] = wdata[4]; end
         if (wr && addr == 8'h7C) m_wk = wdata[1];
         if (wr && addr == 8'h9A) m_pc = wdata[0];
         if (wr && addr == 8'h9A && !wdata[0]) m_off = 0;
         else if (ev[1] && pc_old) m_off = 1;
      end
      #5;
      e_irq  = (m_st[0] & m_ie[0]) | (m_st[1] & m_ie[1]);
      e_wake = m_st[0] & m_wk;
      e_pwr  = !m_off;
      total++;
      if (irq !== e_irq || wake !== e_wake || pwr_en !== e_pwr) begin
         bad++;
         $display("FAIL R5/R6/R7 model compare actual irq=%b wake=%b pwr=%b expected irq=%b wake=%b pwr=%b",
                  irq, wake, pwr_en, e_irq, e_wake, e_pwr);
      end
   end

   function automatic logic [47:0] pack(input logic [7:0] s, mi, h, d, mo, y);
      return {y, mo, d, h, mi, s};
   endfunction

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic step(input bit w, input logic [7:0] a, input logic [7:0] d,
                       input bit t, input logic [47:0] n);
      @(negedge clk);
      wr = w; addr = a; wdata = d; tick = t; now = n;
      @(negedge clk);
      wr = 0; tick = 0;
   endtask

   task automatic wreg(input logic [7:0] a, input logic [7:0] d);
      step(1, a, d, 0, now);
   endtask

   task automatic tk(input logic [47:0] n);
      step(0, 8'h00, 8'h00, 1, n);
   endtask

   task automatic rd_chk(input string tag, input logic [7:0] a, input logic [7:0] exp);
      addr = a;
      #1;
      chk(tag, rdata, exp);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1;
         total++; bad++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin : main
      logic [47:0] t1, t2;
      t1 = pack(8'h30, 8'h15, 8'h12, 8'h25, 8'h06, 8'h24);
      t2 = pack(8'h45, 8'h59, 8'h23, 8'h31, 8'h12, 8'h99);
      repeat (5) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // reset state
      rd_chk("R3 reset status", 8'h44, 8'h00);
      chk("R7 reset pwr_en", {7'b0, pwr_en}, 8'h01);
      chk("R5 reset irq", {7'b0, irq}, 8'h00);
      rd_chk("R1 reset field", 8'h94, 8'h00);

      // R1 program both alarms
      for (int f = 0; f < 6; f++) wreg(8'(8'h20 + 4*f), t1[8*f +: 8]);
      for (int f = 0; f < 6; f++) wreg(8'(8'h80 + 4*f), t2[8*f +: 8]);
      rd_chk("R1 alarm1 day", 8'h2C, 8'h25);
      rd_chk("R1 alarm1 year", 8'h34, 8'h24);
      rd_chk("R1 alarm2 hours", 8'h88, 8'h23);

      // R2 single mismatches
      tk({8'h25, t1[39:0]});
      rd_chk("R2 year mismatch", 8'h44, 8'h00);
      tk({t1[47:8], 8'h31});
      rd_chk("R2 seconds mismatch", 8'h44, 8'h00);

      // R10 match without strobe
      for (int i = 0; i < 3; i++) step(0, 8'h00, 8'h00, 0, t1);
      rd_chk("R10 no strobe", 8'h44, 8'h00);

      // R3 full match
      tk(t1);
      rd_chk("R3 alarm1 flag", 8'h44, 8'h40);
      chk("R5 irq masked", {7'b0, irq}, 8'h00);
      wreg(8'h48, 8'h08);
      chk("R5 irq enabled", {7'b0, irq}, 8'h01);
      wreg(8'h7C, 8'h02);
      chk("R6 wake", {7'b0, wake}, 8'h01);
      rd_chk("R5 ien readback", 8'h48, 8'h08);
      rd_chk("R6 wake readback", 8'h7C, 8'h02);

      // R4 write-one-to-clear
      wreg(8'h44, 8'h80);
      rd_chk("R4 other bit", 8'h44, 8'h40);
      wreg(8'h44, 8'h00);
      rd_chk("R4 zero write", 8'h44, 8'h40);
      wreg(8'h44, 8'h40);
      rd_chk("R4 cleared", 8'h44, 8'h00);
      chk("R5 irq after clear", {7'b0, irq}, 8'h00);
      chk("R6 wake after clear", {7'b0, wake}, 8'h00);
      step(1, 8'h44, 8'h40, 1, t1);
      rd_chk("R4 event beats clear", 8'h44, 8'h40);
      wreg(8'h44, 8'h40);

      // R9 write in strobe cycle applies one strobe late
      step(1, 8'h20, 8'h31, 1, {t1[47:8], 8'h31});
      rd_chk("R9 late write no event", 8'h44, 8'h00);
      rd_chk("R9 written value", 8'h20, 8'h31);
      tk({t1[47:8], 8'h31});
      rd_chk("R9 next strobe event", 8'h44, 8'h40);
      wreg(8'h44, 8'h40);

      // R7 alarm 2 without power control
      wreg(8'h48, 8'h18);
      tk(t2);
      rd_chk("R3 alarm2 flag", 8'h44, 8'h80);
      chk("R5 alarm2 irq", {7'b0, irq}, 8'h01);
      chk("R7 disarmed stays on", {7'b0, pwr_en}, 8'h01);
      wreg(8'h44, 8'h80);

      // R7 armed
      wreg(8'h9A, 8'h01);
      rd_chk("R7 ctl readback", 8'h9A, 8'h01);
      chk("R7 armed idle on", {7'b0, pwr_en}, 8'h01);
      tk(t2);
      chk("R7 armed event off", {7'b0, pwr_en}, 8'h00);

      // R8 sticky off
      wreg(8'h44, 8'h80);
      chk("R8 clear flag keeps off", {7'b0, pwr_en}, 8'h00);
      tk(t1);
      chk("R8 strobe keeps off", {7'b0, pwr_en}, 8'h00);
      wreg(8'h9A, 8'h00);
      chk("R8 disarm restores", {7'b0, pwr_en}, 8'h01);

      // R8 reset restores
      wreg(8'h9A, 8'h01);
      tk(t2);
      chk("R8 off again", {7'b0, pwr_en}, 8'h00);
      rst_n = 0;
      repeat (2) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk("R8 reset restores", {7'b0, pwr_en}, 8'h01);
      rd_chk("R3 status after reset", 8'h44, 8'h00);
      rd_chk("R1 field after reset", 8'h20, 8'h00);

      repeat (3) @(negedge clk);
      if (!done) begin
         done = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule